// File: doc/BRIEF.md
# Skip and Branch Sequencing Controller

This block sits beside the execute stage of a small in-order pipelined processor. It decides how many cycles each instruction occupies and which instructions are thrown away instead of executed. Each cycle, the decoder offers one instruction slot. The slot carries an instruction-class code and, for a conditional skip, the already-resolved skip condition. The controller answers with three things. A hold flag says that the slot is not consumed this cycle. A squash flag says that the next consumed slot is to be discarded. A refill counter shows how many pipeline-refill cycles remain after a change of flow.

A conditional skip that is taken discards the following instruction. If that discarded instruction is a page-select or an immediate-high/low load prefix, the discard carries on through the whole run of prefixes. It also takes out the first non-prefix instruction after the run. A skip placed in front of a prefixed far jump therefore acts as one conditional branch. This extended skip can be interrupted at any slot boundary. The pending skip state is saved when an interrupt is accepted and restored by the return-from-interrupt instruction, so the rest of the run is still discarded after the return.

Top module: `brseq_ctrl`

## Requirements
- R1: Class codes on `slot_cls` are: ordinary 0, multiply 1, page prefix 2, load-high prefix 3, load-low prefix 4, conditional skip 5, jump 6, call 7, return 8, return-from-interrupt 9, instruction-memory read 10, instruction-memory write 11. After synchronous reset, `hold`, `squash`, `ext_skip`, `irq_take` and `refill_left` are all 0.
- R2: An executed (not squashed) jump, call, return or return-from-interrupt occupies 3 cycles. These are its own slot plus 2 refill cycles, during which `refill_left` reads 2 and then 1 and `hold` is high.
- R3: An executed conditional skip with `skip_hit` low occupies 1 cycle and leaves `squash` low for the next slot.
- R4: An executed conditional skip with `skip_hit` high occupies 1 cycle and raises `squash`, so the next consumed slot is discarded. A skip over one ordinary instruction therefore spans 2 cycles.
- R5: A squashed slot holding a page, load-high or load-low prefix keeps `squash` high for the following slot. The first squashed non-prefix ends the skip. `ext_skip` is high for every squashed slot that follows at least one squashed prefix.
- R6: A squashed slot takes exactly 1 cycle whatever its class. It starts no refill, no stall and no new skip.
- R7: An executed instruction-memory read or write occupies 4 cycles, with `hold` high for the 3 cycles after its slot.
- R8: Ordinary and multiply instructions occupy 1 cycle.
- R9: An `irq_req` seen in any cycle with `hold` low is accepted, including inside an extended skip. The slot offered in that cycle is not consumed. `irq_take` is high in the next cycle, and the acceptance is followed by 2 refill cycles, 3 cycles in all.
- R10: Accepting an interrupt saves the pending skip and extended-skip state and clears it. An executed return-from-interrupt restores the saved state, so the re-offered instructions are still discarded.
- R11: While `hold` is high, `slot_vld`, `slot_cls`, `skip_hit` and `irq_req` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | 1 | An instruction is offered in this cycle |
| slot_cls | input | 4 | Class code of the offered instruction (see R1) |
| skip_hit | input | 1 | Resolved condition of an offered conditional skip: 1 means skip |
| irq_req | input | 1 | Interrupt request, accepted at a free slot |
| hold | output | 1 | Slot not consumed this cycle (refill or memory transfer) |
| squash | output | 1 | The next consumed slot is discarded |
| ext_skip | output | 1 | The squash belongs to an extended skip past a prefix |
| refill_left | output | 2 | Remaining branch refill cycles |
| irq_take | output | 1 | Pulse: an interrupt was accepted in the previous cycle |

## Verification
Plain straight-line code of ordinary, multiply, branch and transfer classes separates the 1, 3 and 4 cycle occupancies from one another. Skips with the condition false and with it true, followed by runs of zero to three prefixes and then a branch, separate a single skip from an extended one and show where the chain must stop. Squashed branch, transfer and skip instructions show that a discarded slot has no side effects. Interrupts taken outside a skip, right after a taken skip and in the middle of a prefix chain, each followed by a return, tell apart a controller that saves and restores the skip state from one that loses it. Class and interrupt inputs driven during a transfer stall check that held cycles ignore their inputs.

// File: rtl/brseq_pkg.sv
package brseq_pkg;

  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    C_ORD  = 4'd0,
    C_MUL  = 4'd1,
    C_PAGE = 4'd2,
    C_LDH  = 4'd3,
    C_LDL  = 4'd4,
    C_SKIP = 4'd5,
    C_JMP  = 4'd6,
    C_CALL = 4'd7,
    C_RET  = 4'd8,
    C_RETI = 4'd9,
    C_IRD  = 4'd10,
    C_IWR  = 4'd11
  } ins_cls_e;

  function automatic logic is_prefix(input ins_cls_e c);
    return (c == C_PAGE) || (c == C_LDH) || (c == C_LDL);
  endfunction

  function automatic logic is_flow(input ins_cls_e c);
    return (c == C_JMP) || (c == C_CALL) || (c == C_RET) || (c == C_RETI);
  endfunction

  function automatic logic is_xfer(input ins_cls_e c);
    return (c == C_IRD) || (c == C_IWR);
  endfunction

endpackage

// File: rtl/brseq_hold.sv
module brseq_hold #(
  parameter int REFILL_CYC = 2,
  parameter int XFER_CYC   = 4,
  parameter int RF_W       = $clog2(REFILL_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_refill,
  input  logic            start_xfer,
  output logic            hold,
  output logic [RF_W-1:0] refill_left
);

  localparam int XF_W = (XFER_CYC > 2) ? $clog2(XFER_CYC) : 1;

  logic [RF_W-1:0] rf_cnt;
  logic [XF_W-1:0] xf_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_cnt <= '0;
      xf_cnt <= '0;
    end else begin
      if (start_refill)
        rf_cnt <= RF_W'(REFILL_CYC);
      else if (rf_cnt != '0)
        rf_cnt <= rf_cnt - 1'b1;

      if (start_xfer)
        xf_cnt <= XF_W'(XFER_CYC - 1);
      else if (xf_cnt != '0)
        xf_cnt <= xf_cnt - 1'b1;
    end
  end

  assign hold        = (rf_cnt != '0) || (xf_cnt != '0);
  assign refill_left = rf_cnt;

endmodule

// File: rtl/brseq_skip.sv
module brseq_skip
  import brseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     take_irq,
  input  logic     take_ins,
  input  ins_cls_e cls,
  input  logic     hit,
  output logic     skipping,
  output logic     chained
);

  logic saved_skip;
  logic saved_chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      skipping    <= 1'b0;
      chained     <= 1'b0;
      saved_skip  <= 1'b0;
      saved_chain <= 1'b0;
    end else if (take_irq) begin
      // park the unfinished skip for the return path
      saved_skip  <= skipping;
      saved_chain <= chained;
      skipping    <= 1'b0;
      chained     <= 1'b0;
    end else if (take_ins) begin
      if (skipping) begin
        // a discarded prefix stretches the skip over the next slot too
        skipping <= is_prefix(cls);
        chained  <= is_prefix(cls);
      end else if (cls == C_SKIP) begin
        skipping <= hit;
        chained  <= 1'b0;
      end else if (cls == C_RETI) begin
        skipping    <= saved_skip;
        chained     <= saved_chain;
        saved_skip  <= 1'b0;
        saved_chain <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/brseq_ctrl.sv
module brseq_ctrl
  import brseq_pkg::*;
#(
  parameter int REFILL_CYC = 2,
  parameter int XFER_CYC   = 4,
  parameter int RF_W       = $clog2(REFILL_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slot_vld,
  input  logic [CLS_W-1:0] slot_cls,
  input  logic            skip_hit,
  input  logic            irq_req,
  output logic            hold,
  output logic            squash,
  output logic            ext_skip,
  output logic [RF_W-1:0] refill_left,
  output logic            irq_take
);

  ins_cls_e cls;
  logic     take_irq, take_ins, exec;
  logic     skipping, chained;

  assign cls      = ins_cls_e'(slot_cls);
  assign take_irq = !hold && irq_req;
  assign take_ins = !hold && !irq_req && slot_vld;
  assign exec     = take_ins && !skipping;

  brseq_hold #(
    .REFILL_CYC(REFILL_CYC),
    .XFER_CYC  (XFER_CYC),
    .RF_W      (RF_W)
  ) u_hold (
    .clk         (clk),
    .rst         (rst),
    .start_refill(take_irq || (exec && is_flow(cls))),
    .start_xfer  (exec && is_xfer(cls)),
    .hold        (hold),
    .refill_left (refill_left)
  );

  brseq_skip u_skip (
    .clk     (clk),
    .rst     (rst),
    .take_irq(take_irq),
    .take_ins(take_ins),
    .cls     (cls),
    .hit     (skip_hit),
    .skipping(skipping),
    .chained (chained)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_take <= 1'b0;
    else     irq_take <= take_irq;
  end

  assign squash   = skipping;
  assign ext_skip = skipping && chained;

endmodule

// File: rtl/brseq_chk.sv
module brseq_chk
  import brseq_pkg::*;
#(
  parameter int REFILL_CYC = 2,
  parameter int RF_W       = $clog2(REFILL_CYC + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            slot_vld,
  input logic [CLS_W-1:0] slot_cls,
  input logic            skip_hit,
  input logic            irq_req,
  input logic            hold,
  input logic            squash,
  input logic            ext_skip,
  input logic [RF_W-1:0] refill_left,
  input logic            irq_take
);

  logic run_ins;
  assign run_ins = !hold && !irq_req && slot_vld && !squash;

  // R2: executed change of flow loads the full refill count
  p_flow_refill_r2: assert property (@(posedge clk) disable iff (rst)
    (run_ins && is_flow(ins_cls_e'(slot_cls))) |=> (refill_left == RF_W'(REFILL_CYC)));

  // R2: refill counts down one per cycle and stalls the slot
  p_refill_down_r2: assert property (@(posedge clk) disable iff (rst)
    (refill_left != '0) |=> (refill_left == $past(refill_left) - 1'b1));

  p_refill_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (refill_left != '0) |-> hold);

  // R4: a taken skip marks the next slot for discard
  p_skip_arms_r4: assert property (@(posedge clk) disable iff (rst)
    (run_ins && ins_cls_e'(slot_cls) == C_SKIP && skip_hit) |=> squash);

  // R3: a skip whose condition is false discards nothing
  p_skip_miss_r3: assert property (@(posedge clk) disable iff (rst)
    (run_ins && ins_cls_e'(slot_cls) == C_SKIP && !skip_hit) |=> !squash);

  // R5: chain stops after the first non-prefix; extension implies squash
  p_chain_end_r5: assert property (@(posedge clk) disable iff (rst)
    (!hold && !irq_req && slot_vld && squash && !is_prefix(ins_cls_e'(slot_cls))) |=> !squash);

  p_ext_sub_r5: assert property (@(posedge clk) disable iff (rst)
    ext_skip |-> squash);

  // R6: a discarded slot never stalls
  p_kill_free_r6: assert property (@(posedge clk) disable iff (rst)
    (!hold && !irq_req && slot_vld && squash) |=> !hold);

  // R9: interrupt at a free slot is acknowledged next cycle
  p_irq_ack_r9: assert property (@(posedge clk) disable iff (rst)
    (!hold && irq_req) |=> (irq_take && !squash && refill_left == RF_W'(REFILL_CYC)));

  // R11: no acknowledge while held
  p_hold_ignores_r11: assert property (@(posedge clk) disable iff (rst)
    hold |=> !irq_take);

endmodule

bind brseq_ctrl brseq_chk #(
  .REFILL_CYC(REFILL_CYC),
  .RF_W      (RF_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slot_vld   (slot_vld),
  .slot_cls   (slot_cls),
  .skip_hit   (skip_hit),
  .irq_req    (irq_req),
  .hold       (hold),
  .squash     (squash),
  .ext_skip   (ext_skip),
  .refill_left(refill_left),
  .irq_take   (irq_take)
);

// File: tb/brseq_ctrl_tb.sv
module brseq_ctrl_tb;
  import brseq_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slot_vld = 1'b0;
  logic [3:0] slot_cls = 4'd0;
  logic       skip_hit = 1'b0;
  logic       irq_req = 1'b0;
  logic       hold, squash, ext_skip, irq_take;
  logic [1:0] refill_left;

  always #4 clk = ~clk;  // 125 MHz

  brseq_ctrl u_dut (
    .clk(clk), .rst(rst), .slot_vld(slot_vld), .slot_cls(slot_cls),
    .skip_hit(skip_hit), .irq_req(irq_req), .hold(hold), .squash(squash),
    .ext_skip(ext_skip), .refill_left(refill_left), .irq_take(irq_take)
  );

  typedef struct {
    logic  is_irq;
    logic  sq;
    logic  ext;
    int    cyc;
    string tag;
  } exp_t;

  exp_t  expq[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    run = 1'b0;
  bit    done = 1'b0;
  string tag_force = "";

  // reference model state
  bit m_skip = 0, m_chain = 0, m_sv_skip = 0, m_sv_chain = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_free();
    while (hold) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic issue(input ins_cls_e c, input bit hit);
    exp_t e;
    e.is_irq = 0;
    e.sq  = m_skip;
    e.ext = m_skip && m_chain;
    if (m_skip) begin
      e.cyc = 1; e.tag = m_chain ? "R5" : "R6";
      m_skip  = (c == C_PAGE || c == C_LDH || c == C_LDL);
      m_chain = m_skip;
    end else begin
      case (c)
        C_SKIP: begin e.cyc = 1; e.tag = hit ? "R4" : "R3"; m_skip = hit; m_chain = 0; end
        C_JMP, C_CALL, C_RET: begin e.cyc = 3; e.tag = "R2"; end
        C_RETI: begin
          e.cyc = 3; e.tag = "R10";
          m_skip = m_sv_skip; m_chain = m_sv_chain; m_sv_skip = 0; m_sv_chain = 0;
        end
        C_IRD, C_IWR: begin e.cyc = 4; e.tag = "R7"; end
        default: begin e.cyc = 1; e.tag = "R8"; end
      endcase
    end
    if (tag_force != "") e.tag = tag_force;
    expq.push_back(e);
    wait_free();
    slot_vld = 1'b1; slot_cls = c; skip_hit = hit;
    @(posedge clk); #1;
    slot_vld = 1'b0; skip_hit = 1'b0;
  endtask

  task automatic take_irq();
    exp_t e;
    e.is_irq = 1; e.sq = 0; e.ext = 0; e.cyc = 3; e.tag = "R9";
    m_sv_skip = m_skip; m_sv_chain = m_chain; m_skip = 0; m_chain = 0;
    expq.push_back(e);
    wait_free();
    irq_req = 1'b1;
    @(posedge clk); #1;
    irq_req = 1'b0;
  endtask

  // monitor / scoreboard
  bit   pend = 0, ack_chk = 0, ack_exp = 0;
  int   cnt = 0;
  logic o_sq, o_ext, o_irq;

  always @(negedge clk) begin
    if (!rst && run) begin
      if (ack_chk) begin
        check(irq_take == ack_exp, "R9 irq_take", int'(irq_take), int'(ack_exp));
        ack_chk = 0;
      end
      if (pend) begin
        if (hold) cnt++;
        else begin
          exp_t e;
          pend = 0;
          if (expq.size() == 0) check(0, "R2 unexpected slot", 1, 0);
          else begin
            e = expq.pop_front();
            check(cnt == e.cyc, {e.tag, " cycles"}, cnt, e.cyc);
            check(o_irq == e.is_irq, {e.tag, " event kind"}, int'(o_irq), int'(e.is_irq));
            if (!e.is_irq) begin
              check(o_sq == e.sq, {e.tag, " squash"}, int'(o_sq), int'(e.sq));
              check(o_ext == e.ext, {e.tag, " ext_skip"}, int'(o_ext), int'(e.ext));
            end
          end
        end
      end
      if (!hold && (irq_req || slot_vld)) begin
        pend = 1; cnt = 1;
        o_irq = irq_req; o_sq = squash; o_ext = ext_skip;
        ack_chk = 1; ack_exp = irq_req;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!hold && !squash && !ext_skip && !irq_take && refill_left == 2'd0,
          "R1 reset outputs", int'({hold, squash, ext_skip, irq_take, refill_left}), 0);
    @(posedge clk); #1;
    run = 1'b1;

    // R8 / R3 straight code
    issue(C_ORD, 0); issue(C_MUL, 0); issue(C_SKIP, 0); issue(C_ORD, 0);
    // R4 single skip
    issue(C_SKIP, 1); issue(C_ORD, 0); issue(C_MUL, 0);
    // R5 skip over page + jump
    issue(C_SKIP, 1); issue(C_PAGE, 0); issue(C_JMP, 0); issue(C_ORD, 0);
    // R5 skip over a run of three prefixes + call
    issue(C_SKIP, 1); issue(C_LDH, 0); issue(C_LDL, 0); issue(C_PAGE, 0);
    issue(C_CALL, 0); issue(C_MUL, 0);
    // R2 / R7 flow and transfer
    issue(C_JMP, 0); issue(C_RET, 0); issue(C_IRD, 0); issue(C_IWR, 0); issue(C_CALL, 0);
    // R6 squashed slots have no side effects
    issue(C_SKIP, 1); issue(C_IRD, 0); issue(C_SKIP, 1); issue(C_JMP, 0);
    issue(C_SKIP, 1); issue(C_SKIP, 1); issue(C_ORD, 0);
    // R11 inputs driven while held by a transfer are ignored
    tag_force = "R11";
    issue(C_IWR, 0);
    slot_vld = 1'b1; slot_cls = C_JMP; irq_req = 1'b1;
    @(posedge clk); #1;
    slot_vld = 1'b0; irq_req = 1'b0;
    tag_force = "";
    issue(C_ORD, 0);
    // R9 / R10 interrupt outside a skip
    take_irq(); issue(C_ORD, 0); issue(C_RETI, 0); issue(C_ORD, 0);
    // R10 interrupt right after a taken skip
    issue(C_SKIP, 1); take_irq(); issue(C_MUL, 0); issue(C_RETI, 0);
    issue(C_JMP, 0); issue(C_ORD, 0);
    // R10 interrupt in the middle of a prefix chain
    issue(C_SKIP, 1); issue(C_PAGE, 0); take_irq(); issue(C_ORD, 0); issue(C_IRD, 0);
    issue(C_RETI, 0); issue(C_LDL, 0); issue(C_JMP, 0); issue(C_ORD, 0);

    repeat (8) @(posedge clk);
    check(expq.size() == 0, "R2 expected items left", expq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule